// File: doc/BRIEF.md
# Run-Length Waveform Capture Compressor

This block records the history of up to 24 probe signals and sends it out in compressed form. A software-writable mask register selects which probes are watched. A probe whose mask bit is clear reads as zero. Each clock, the encoder samples the masked probe word and tracks how many consecutive cycles that word has kept the same value. When the word changes, it emits one 32-bit packet: the repeat count sits in the top byte and the masked sample in the low 24 bits. The packets go into a 128-entry buffer, and an AXI4-Stream master port drains that buffer. The port raises TLAST after every N beats, where N is the programmed packet length.

The encoder is a two-state machine. ENC_IDLE means capture is off (mask all zero). Its only exit is the transition *arm*: when the mask becomes nonzero, the machine loads the current masked word with a count of 1 and goes to ENC_RUN. ENC_RUN has four transitions:

- *extend*: the word is unchanged, so the count goes up by one.
- *change*: the word differs, so the machine emits the finished run and starts a new one at count 1.
- *split*: the word is unchanged but the count already reads 255, so the machine emits a 255 packet and restarts at 1.
- *disarm*: the mask becomes zero, so the machine emits the pending run and returns to ENC_IDLE.

A packet that arrives when the buffer is full is lost. An all-zero word then marks the loss in the stream. A hysteresis flag reports when the buffer is nearly full. An AXI-Lite slave holds four registers: mask, high threshold, low threshold and packet length.

Top module: `rle_capture`

## Requirements
- R1: Each packet is {count[31:24], masked sample[23:0]}. A run closes and is emitted on the first cycle whose masked word differs from the run's word, and its count equals the number of cycles the word was held.
- R2: The count of a run starts at 1 and never exceeds 255. A word held for more than 255 sampled cycles yields a packet with count 255, and the run continues from count 1.
- R3: Probe i is sampled only when mask bit i is 1. Changes on unmasked probes produce no packet. With an all-zero mask, no packet is produced at all.
- R4: Writing an all-zero mask while a run is pending emits that run, with its count so far, as one packet.
- R5: The buffer holds 128 packets. Fullness is judged at the start of each cycle. A packet that finds the buffer full is dropped. Once space exists, exactly one all-zero packet is queued. That zero packet stands for all packets lost up to and including the cycle in which it is written.
- R6: `buf_high` sets on the cycle after occupancy is at or above the high threshold. It clears on the cycle after occupancy is at or below the low threshold while below the high threshold. Otherwise it holds its value.
- R7: `m_tlast` is high on the last beat of each group of N beats, where N is the length register. A value of 0 or 1 marks every beat.
- R8: The registers are the mask at 0x0 (24 bits, reset 0), the high threshold at 0x4 (7 bits, reset 0x40), the low threshold at 0x8 (7 bits, reset 0x10) and the length at 0xC (7 bits, reset 8). They read back what was written, and reads of other addresses return 0.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and `m_tdata` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe | input | 24 | Signals under observation |
| s_awvalid | input | 1 | Register write address valid |
| s_awready | output | 1 | Register write address accepted |
| s_awaddr | input | 4 | Register write byte address |
| s_wvalid | input | 1 | Register write data valid |
| s_wready | output | 1 | Register write data accepted |
| s_wdata | input | 24 | Register write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_arvalid | input | 1 | Register read address valid |
| s_arready | output | 1 | Register read address accepted |
| s_araddr | input | 4 | Register read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| s_rdata | output | 24 | Read data |
| m_tvalid | output | 1 | Packet stream valid |
| m_tready | input | 1 | Packet stream ready |
| m_tdata | output | 32 | Packet |
| m_tlast | output | 1 | Last beat of a group |
| buf_high | output | 1 | Buffer-high hysteresis flag |

## Verification
The bench aims at the following corner cases, and each one catches a specific mistake.

- A held word runs past 255 cycles. An encoder without the split would wrap its count to 0 and put a fake overflow marker into the stream.
- The mask is cleared mid-run. An encoder that drops the pending run on disarm would lose the final packet.
- The stream stalls long enough to overflow the buffer, then drains. A wrong loss rule would emit no zero marker, or several markers, or would overwrite queued data.
- The buffer drains through the thresholds. An off-by-one threshold compare would shift the flag's edges by a cycle.
- Toggles are confined to unmasked probes. A mask applied in the wrong place would show up as spurious packets.

// File: rtl/rle_pkg.sv
package rle_pkg;
    typedef enum logic {
        ENC_IDLE,
        ENC_RUN
    } enc_state_t;

    localparam logic [3:0] ADDR_MASK = 4'h0;
    localparam logic [3:0] ADDR_HI   = 4'h4;
    localparam logic [3:0] ADDR_LO   = 4'h8;
    localparam logic [3:0] ADDR_LEN  = 4'hC;
endpackage

// File: rtl/rle_regs.sv
module rle_regs #(
    parameter int DATA_W = 24,
    parameter int TH_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [3:0]        awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    output logic              bvalid,
    input  logic              bready,
    input  logic              arvalid,
    output logic              arready,
    input  logic [3:0]        araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mask,
    output logic [TH_W-1:0]   hi_th,
    output logic [TH_W-1:0]   lo_th,
    output logic [TH_W-1:0]   grp_len
);
    import rle_pkg::*;

    logic wr_fire;
    assign wr_fire = awvalid && wvalid && !bvalid;
    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign arready = !rvalid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '0;
            hi_th   <= TH_W'(7'h40);
            lo_th   <= TH_W'(7'h10);
            grp_len <= TH_W'(8);
            bvalid  <= 1'b0;
        end else begin
            if (wr_fire) begin
                bvalid <= 1'b1;
                unique case (awaddr)
                    ADDR_MASK: mask    <= wdata;
                    ADDR_HI:   hi_th   <= wdata[TH_W-1:0];
                    ADDR_LO:   lo_th   <= wdata[TH_W-1:0];
                    ADDR_LEN:  grp_len <= wdata[TH_W-1:0];
                    default: ;
                endcase
            end else if (bready) begin
                bvalid <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (arvalid && !rvalid) begin
            rvalid <= 1'b1;
            unique case (araddr)
                ADDR_MASK: rdata <= mask;
                ADDR_HI:   rdata <= DATA_W'(hi_th);
                ADDR_LO:   rdata <= DATA_W'(lo_th);
                ADDR_LEN:  rdata <= DATA_W'(grp_len);
                default:   rdata <= '0;
            endcase
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/rle_encoder.sv
module rle_encoder #(
    parameter int PROBE_W = 24,
    parameter int CNT_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PROBE_W-1:0]       probe,
    input  logic [PROBE_W-1:0]       mask,
    output logic                     pkt_valid,
    output logic [CNT_W+PROBE_W-1:0] pkt_data
);
    import rle_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    enc_state_t         state, state_nxt;
    logic [PROBE_W-1:0] masked, cur;
    logic [CNT_W-1:0]   cnt;
    logic               armed;

    assign masked = probe & mask;
    assign armed  = |mask;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ENC_IDLE: if (armed)  state_nxt = ENC_RUN;
            ENC_RUN:  if (!armed) state_nxt = ENC_IDLE;
            default:  state_nxt = ENC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENC_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur       <= '0;
            cnt       <= '0;
            pkt_valid <= 1'b0;
            pkt_data  <= '0;
        end else begin
            pkt_valid <= 1'b0;
            unique case (state)
                ENC_IDLE: begin
                    if (armed) begin
                        cur <= masked;
                        cnt <= CNT_ONE;
                    end
                end
                ENC_RUN: begin
                    if (!armed) begin
                        pkt_valid <= 1'b1;
                        pkt_data  <= {cnt, cur};
                    end else if (masked != cur) begin
                        pkt_valid <= 1'b1;
                        pkt_data  <= {cnt, cur};
                        cur       <= masked;
                        cnt       <= CNT_ONE;
                    end else if (cnt == CNT_MAX) begin
                        pkt_valid <= 1'b1;
                        pkt_data  <= {cnt, cur};
                        cnt       <= CNT_ONE;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_data[CNT_W+PROBE_W-1:PROBE_W] != '0); // R2
    AST_RUN_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENC_RUN && armed && masked == cur && cnt == CNT_MAX)
        |=> (pkt_valid && pkt_data[CNT_W+PROBE_W-1:PROBE_W] == CNT_MAX)); // R2
    AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENC_IDLE) |=> !pkt_valid); // R3
    AST_DISARM_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENC_RUN && !armed) |=> pkt_valid); // R4
endmodule

// File: rtl/rle_fifo.sv
module rle_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [W-1:0]               out_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          pop;

    assign full      = (level == CW'(DEPTH));
    assign out_valid = (level != '0);
    assign out_data  = mem[rp];
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + PW'(1);
            if (pop)  rp <= (rp == LAST) ? '0 : rp + PW'(1);
            level <= level + CW'(push) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH)); // R5
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
endmodule

// File: rtl/rle_capture.sv
module rle_capture #(
    parameter int PROBE_W = 24,
    parameter int CNT_W   = 8,
    parameter int DEPTH   = 128,
    parameter int TH_W    = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PROBE_W-1:0]       probe,
    input  logic                     s_awvalid,
    output logic                     s_awready,
    input  logic [3:0]               s_awaddr,
    input  logic                     s_wvalid,
    output logic                     s_wready,
    input  logic [PROBE_W-1:0]       s_wdata,
    output logic                     s_bvalid,
    input  logic                     s_bready,
    input  logic                     s_arvalid,
    output logic                     s_arready,
    input  logic [3:0]               s_araddr,
    output logic                     s_rvalid,
    input  logic                     s_rready,
    output logic [PROBE_W-1:0]       s_rdata,
    output logic                     m_tvalid,
    input  logic                     m_tready,
    output logic [CNT_W+PROBE_W-1:0] m_tdata,
    output logic                     m_tlast,
    output logic                     buf_high
);
    localparam int PKT_W = CNT_W + PROBE_W;
    localparam int LV_W  = $clog2(DEPTH + 1);
    localparam int BW    = TH_W + 1;

    logic [PROBE_W-1:0] mask;
    logic [TH_W-1:0]    hi_th, lo_th, grp_len;
    logic               pkt_valid, full, push, mark, loss_pend;
    logic [PKT_W-1:0]   pkt_data;
    logic [LV_W-1:0]    level;
    logic [TH_W-1:0]    beat;

    rle_regs #(.DATA_W(PROBE_W), .TH_W(TH_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
        .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata),
        .bvalid(s_bvalid), .bready(s_bready),
        .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
        .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata),
        .mask(mask), .hi_th(hi_th), .lo_th(lo_th), .grp_len(grp_len)
    );

    rle_encoder #(.PROBE_W(PROBE_W), .CNT_W(CNT_W)) i_enc (
        .clk(clk), .rst_n(rst_n), .probe(probe), .mask(mask),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data)
    );

    assign mark = loss_pend && !full;
    assign push = mark || (pkt_valid && !full && !loss_pend);

    rle_fifo #(.W(PKT_W), .DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(mark ? '0 : pkt_data),
        .full(full), .level(level),
        .out_valid(m_tvalid), .out_ready(m_tready), .out_data(m_tdata)
    );

    assign m_tlast = ({1'b0, beat} + BW'(1)) >= {1'b0, grp_len};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loss_pend <= 1'b0;
            beat      <= '0;
            buf_high  <= 1'b0;
        end else begin
            if (mark)                   loss_pend <= 1'b0;
            else if (pkt_valid && full) loss_pend <= 1'b1;
            if (m_tvalid && m_tready)   beat <= m_tlast ? '0 : beat + TH_W'(1);
            if (level >= LV_W'(hi_th))      buf_high <= 1'b1;
            else if (level <= LV_W'(lo_th)) buf_high <= 1'b0;
        end
    end

    AST_HIGH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= LV_W'(hi_th)) |=> buf_high); // R6
    AST_MARK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_is_zero()) |=> !loss_pend); // R5

    function automatic logic push_is_zero();
        return mark;
    endfunction
endmodule

// File: tb/test_rle_capture.sv
`timescale 1ns/1ps
module test_rle_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] probe = '0;
    logic        s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
    logic [3:0]  s_awaddr = '0, s_araddr = '0;
    logic [23:0] s_wdata = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [23:0] s_rdata;
    logic        m_tvalid, m_tlast, buf_high;
    logic        m_tready = 1'b1;
    logic [31:0] m_tdata;

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [23:0] r_mask = '0;
    int          r_hi = 'h40, r_lo = 'h10, r_len = 8;
    bit          e_on = 0;
    logic [23:0] e_cur = '0;
    int          e_cnt = 0;
    bit          pv = 0;
    logic [31:0] pd = '0;
    logic [31:0] q[$];
    bit          lost = 0;
    int          beat = 0;
    bit          bh = 0;

    always #4 clk = ~clk;

    rle_capture i_rle_capture (
        .clk(clk), .rst_n(rst_n), .probe(probe),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
        .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tlast(m_tlast), .buf_high(buf_high)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // one clock: advance the model from pre-edge values, then compare outputs
    task automatic tick();
        int  sz = q.size();
        bit  full = (sz == 128);
        bit  mark = lost && !full;
        bit  pushp = pv && !full && !lost;
        logic [23:0] mk = probe & r_mask;
        bit  npv = 0;
        logic [31:0] npd = pd;
        if (sz >= r_hi) bh = 1; else if (sz <= r_lo) bh = 0;
        if (sz > 0 && m_tready) begin
            bit last = (beat + 1) >= r_len;
            beat = last ? 0 : beat + 1;
            void'(q.pop_front());
        end
        if (mark) begin q.push_back(32'h0); lost = 0; end
        else if (pushp) q.push_back(pd);
        else if (pv && full) lost = 1;
        if (!e_on) begin
            if (mk != 0) begin e_on = 1; e_cur = mk; e_cnt = 1; end
        end else if (mk == 0) begin
            npv = 1; npd = {8'(e_cnt), e_cur}; e_on = 0;
        end else if (mk != e_cur) begin
            npv = 1; npd = {8'(e_cnt), e_cur}; e_cur = mk; e_cnt = 1;
        end else if (e_cnt == 255) begin
            npv = 1; npd = {8'(e_cnt), e_cur}; e_cnt = 1;
        end else e_cnt++;
        pv = npv; pd = npd;
        @(posedge clk); #1;
        if (rst_n) begin
            check(m_tvalid == (q.size() > 0), "R5/R9 tvalid", 32'(m_tvalid), 32'(q.size() > 0));
            if (q.size() > 0) begin
                check(m_tdata == q[0], "R1/R2/R5 tdata", m_tdata, q[0]);
                check(m_tlast == ((beat + 1) >= r_len), "R7 tlast", 32'(m_tlast), 32'((beat + 1) >= r_len));
            end
            check(buf_high == bh, "R6 buf_high", 32'(buf_high), 32'(bh));
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [23:0] d);
        s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1;
        tick();
        s_awvalid = 0; s_wvalid = 0;
        case (a)
            4'h0: r_mask = d;
            4'h4: r_hi = d[6:0];
            4'h8: r_lo = d[6:0];
            4'hC: r_len = d[6:0];
            default: ;
        endcase
        tick();
    endtask

    task automatic reg_read(input logic [3:0] a, input logic [23:0] exp);
        s_araddr = a; s_arvalid = 1;
        tick();
        s_arvalid = 0;
        check(s_rvalid && s_rdata == exp, "R8 readback", 32'(s_rdata), 32'(exp));
        tick();
    endtask

    task automatic hold(input logic [23:0] v, input int n);
        probe = v;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #1_000_000;
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R8 reset values
        check(!m_tvalid && !buf_high, "R8 reset outputs", 32'({m_tvalid, buf_high}), 0);
        reg_read(4'h0, 24'h0);
        reg_read(4'h4, 24'h40);
        reg_read(4'h8, 24'h10);
        reg_read(4'hC, 24'h8);
        reg_read(4'h6, 24'h0);

        // R3: mask zero, probes toggle, nothing comes out
        for (int i = 0; i < 20; i++) hold(24'(i * 24'h1357), 1);
        check(!m_tvalid, "R3 disabled capture silent", 32'(m_tvalid), 0);

        // R1: runs of differing lengths under a partial mask
        reg_write(4'h0, 24'h0000FF);
        reg_read(4'h0, 24'h0000FF);
        hold(24'h000011, 3); hold(24'h000022, 1); hold(24'h000033, 5);
        // R3: only unmasked bits move, the run must continue
        hold(24'hAB0033, 4); hold(24'h550033, 4);
        hold(24'h000044, 2);
        // R2: long run is split at 255
        hold(24'h0000C3, 600);
        hold(24'h00003C, 2);
        // R4: disarm mid-run flushes pending run
        hold(24'h00005A, 7);
        reg_write(4'h0, 24'h0);
        hold(24'h00005A, 10);
        check(q.size() == 0 && !m_tvalid, "R4 flush drained", 32'(m_tvalid), 0);

        // R7: group length 3, then length 0
        reg_write(4'hC, 24'd3);
        reg_read(4'hC, 24'd3);
        reg_write(4'h0, 24'hFFFFFF);
        for (int i = 0; i < 40; i++) hold(24'(i[0] ? 24'h123456 : 24'h654321), 1 + (i % 3));
        reg_write(4'hC, 24'd0);
        for (int i = 0; i < 10; i++) hold(24'(i + 1), 2);

        // R5/R6/R9: stall, overflow, then drain
        reg_write(4'hC, 24'd8);
        reg_write(4'h4, 24'd40);
        reg_write(4'h8, 24'd12);
        reg_read(4'h4, 24'd40);
        m_tready = 0;
        for (int i = 0; i < 200; i++) hold(24'(i + 24'h100), 1);
        check(q.size() == 128 && lost, "R5 buffer filled with loss pending", 32'(q.size()), 128);
        hold(24'h000777, 20);
        m_tready = 1;
        hold(24'h000777, 200);
        hold(24'h000888, 3);
        reg_write(4'h0, 24'h0);
        hold(24'h0, 10);
        check(!m_tvalid && !buf_high, "R6 drained and flag clear", 32'({m_tvalid, buf_high}), 0);
        finish_run();
    end
endmodule